// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Loader

This block programs up to three external clock synthesizers over a three-wire serial link: data, serial clock and latch strobe. A host requests a transfer. It supplies a channel number, a 3-bit output-divider select, a 9-bit VCO divider and a 7-bit reference divider. The block checks the dividers and the channel against their legal ranges. It then assembles a 24-bit configuration word, whose capacitance, duty-threshold and second-output fields are wired to constants, and shifts the word out on the chosen channel, highest bit first. A latch strobe follows the last bit.

The serial clock comes from the system clock. Each serial-clock level lasts `HALF_CYC` system cycles. The data line changes only while the serial clock is low, because the synthesizer samples data on the rising edge. One transfer runs at a time. A request that fails the range check is refused: no serial activity takes place and a sticky error flag is raised.

Top module: `clksyn_cfg_loader`

## Requirements
- R1: The word sent, first bit to last, is: two zero bits, a one bit, two zero bits, the 3-bit output select (high bit first), the 9-bit VCO divider (high bit first), and the 7-bit reference divider (high bit first). That is 24 bits in total.
- R2: Each serial-clock level lasts exactly `HALF_CYC` system cycles. There are 24 rising edges per transfer, and the data line holds steady for as long as the serial clock is high.
- R3: After the 24th bit, the strobe of the active channel is high for exactly 2*`HALF_CYC` system cycles. The serial clock and the data line of that channel are low while the strobe is high.
- R4: A request whose VCO divider is below 4 is refused. Busy stays low, no output toggles, and the error flag goes high on the cycle after the request.
- R5: A request whose reference divider is 0, or is above 117, is refused in the same way as in R4. The values 1 and 117 are accepted.
- R6: A request for a channel number of 3 or higher is refused in the same way as in R4. Channels 0, 1 and 2 are valid.
- R7: The error flag stays high until reset, including through later transfers that are accepted.
- R8: Busy rises on the cycle after an accepted request and falls on the same edge as the strobe, 50*`HALF_CYC` cycles after it rose. Requests made while busy is high are ignored: they do not change the word being sent and they do not set the error flag.
- R9: Only the selected channel shows activity. While busy is low, every serial clock, data and strobe output is low.
- R10: During reset and after reset, busy, error and all serial outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle transfer request |
| chan_i | input | 2 | Target channel (0 to 2) |
| odsel_i | input | 3 | Output-divider select field |
| vdiv_i | input | 9 | VCO divider (4 to 511) |
| rdiv_i | input | 7 | Reference divider (1 to 117) |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Sticky flag for a refused request |
| sdat_o | output | 3 | Serial data, one bit per channel |
| sclk_o | output | 3 | Serial clock, one bit per channel |
| sstb_o | output | 3 | Latch strobe, one bit per channel |

## Verification
The clash of interest is a new request that arrives while a transfer is still running. The range check and the busy guard would then both act on the same edge. The bench provokes this in two places. The first is mid-shift, with an illegal divider aimed at another channel. The second is the final strobe cycle, on the very edge where busy falls. In both cases the request must be dropped entirely: the captured word still equals the original request, the error flag stays low, and busy does not rise again after the strobe ends.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  localparam int WORD_W = 24;
  localparam int S_W    = 3;
  localparam int V_W    = 9;
  localparam int R_W    = 7;

  localparam logic [V_W-1:0] V_LOW  = 9'd4;
  localparam logic [R_W-1:0] R_LOW  = 7'd1;
  localparam logic [R_W-1:0] R_HIGH = 7'd117;

  // hard-wired leading fields: load cap, duty threshold, second-output source
  localparam logic [1:0] CAP_FIX  = 2'b00;
  localparam logic       DUTY_FIX = 1'b1;
  localparam logic [1:0] FN2_FIX  = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_STROBE = 2'd2
  } ser_state_t;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [S_W-1:0] s,
    input logic [V_W-1:0] v,
    input logic [R_W-1:0] r
  );
    return {CAP_FIX, DUTY_FIX, FN2_FIX, s, v, r};
  endfunction

endpackage

// File: rtl/clksyn_range_chk.sv
module clksyn_range_chk
  import clksyn_pkg::*;
#(
  parameter int NCH  = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CH_W-1:0] chan_i,
  input  logic [V_W-1:0]  vdiv_i,
  input  logic [R_W-1:0]  rdiv_i,
  output logic            legal_o
);

  logic chan_ok, v_ok, r_ok;

  always_comb begin
    chan_ok = ({1'b0, chan_i} < (CH_W+1)'(NCH));
    v_ok    = (vdiv_i >= V_LOW);
    r_ok    = (rdiv_i >= R_LOW) && (rdiv_i <= R_HIGH);
    legal_o = chan_ok && v_ok && r_ok;
  end

endmodule

// File: rtl/clksyn_phase_timer.sv
module clksyn_phase_timer #(
  parameter int HALF_CYC = 2,
  localparam int CW = $clog2(2*HALF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic half_end_o,
  output logic per_end_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
    half_end_o = (cnt_q == CW'(HALF_CYC-1));
    per_end_o  = (cnt_q == CW'(2*HALF_CYC-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/clksyn_serial_fsm.sv
module clksyn_serial_fsm
  import clksyn_pkg::*;
#(
  parameter int HALF_CYC = 2,
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_dat_o,
  output logic              ser_clk_o,
  output logic              ser_stb_o,
  output logic              busy_o
);

  ser_state_t        st_q, st_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              phase_q, phase_d;
  logic              sreg_en, tmr_clr;
  logic              half_end, per_end;

  clksyn_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (tmr_clr),
    .half_end_o (half_end),
    .per_end_o  (per_end)
  );

  always_comb begin
    st_d    = st_q;
    sreg_d  = sreg_q;
    bit_d   = bit_q;
    phase_d = phase_q;
    sreg_en = 1'b0;
    tmr_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          st_d    = ST_SHIFT;
          sreg_d  = word_i;
          sreg_en = 1'b1;
          bit_d   = BW'(WORD_W-1);
          phase_d = 1'b0;
          tmr_clr = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (half_end) begin
          tmr_clr = 1'b1;
          if (!phase_q) begin
            phase_d = 1'b1;
          end else if (bit_q == '0) begin
            phase_d = 1'b0;
            st_d    = ST_STROBE;
          end else begin
            phase_d = 1'b0;
            sreg_d  = {sreg_q[WORD_W-2:0], 1'b0};
            sreg_en = 1'b1;
            bit_d   = bit_q - BW'(1);
          end
        end
      end
      ST_STROBE: begin
        if (per_end) begin
          st_d    = ST_IDLE;
          tmr_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (sreg_en) sreg_q <= sreg_d;
  end

  always_comb begin
    busy_o    = (st_q != ST_IDLE);
    ser_dat_o = (st_q == ST_SHIFT) && sreg_q[WORD_W-1];
    ser_clk_o = (st_q == ST_SHIFT) && phase_q;
    ser_stb_o = (st_q == ST_STROBE);
  end

endmodule

// File: rtl/clksyn_cfg_loader.sv
module clksyn_cfg_loader
  import clksyn_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int HALF_CYC = 2,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic [S_W-1:0]  odsel_i,
  input  logic [V_W-1:0]  vdiv_i,
  input  logic [R_W-1:0]  rdiv_i,
  output logic            busy_o,
  output logic            err_o,
  output logic [NCH-1:0]  sdat_o,
  output logic [NCH-1:0]  sclk_o,
  output logic [NCH-1:0]  sstb_o
);

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic              legal, go, refuse, busy;
  logic              err_q, err_d, err_en;
  logic [CH_W-1:0]   chan_q;
  logic [WORD_W-1:0] word;
  logic              ser_dat, ser_clk, ser_stb;

  clksyn_range_chk #(.NCH(NCH)) u_chk (
    .chan_i  (chan_i),
    .vdiv_i  (vdiv_i),
    .rdiv_i  (rdiv_i),
    .legal_o (legal)
  );

  always_comb begin
    go     = start_i && !busy && legal;
    refuse = start_i && !busy && !legal;
    word   = pack_word(odsel_i, vdiv_i, rdiv_i);
    err_en = refuse;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chan_q <= '0;
    else if (go)     chan_q <= chan_i;
  end

  clksyn_serial_fsm #(.HALF_CYC(HALF_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go_i      (go),
    .word_i    (word),
    .ser_dat_o (ser_dat),
    .ser_clk_o (ser_clk),
    .ser_stb_o (ser_stb),
    .busy_o    (busy)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel;
    assign sel       = (chan_q == CH_W'(g));
    assign sdat_o[g] = sel && ser_dat;
    assign sclk_o[g] = sel && ser_clk;
    assign sstb_o[g] = sel && ser_stb;
  end

  assign busy_o = busy;
  assign err_o  = err_q;

endmodule

// File: rtl/clksyn_loader_sva.sv
module clksyn_loader_sva #(
  parameter int NCH  = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [CH_W-1:0] chan_i,
  input logic [8:0]      vdiv_i,
  input logic [6:0]      rdiv_i,
  input logic            busy_o,
  input logic            err_o,
  input logic [NCH-1:0]  sdat_o,
  input logic [NCH-1:0]  sclk_o,
  input logic [NCH-1:0]  sstb_o
);

  logic req_ok;
  assign req_ok = (vdiv_i > 9'd3) && (rdiv_i != 7'd0) && (rdiv_i < 7'd118)
                  && ({1'b0, chan_i} < (CH_W+1)'(NCH));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sclk_o == '0 && sdat_o == '0 && sstb_o == '0));

  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sclk_o) && $onehot0(sstb_o) && $onehot0(sdat_o));

  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sclk_o & $past(sclk_o))) |-> $stable(sdat_o));

  a_r3_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (|sstb_o) |-> (sclk_o == '0 && sdat_o == '0));

  a_r4_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !req_ok) |=> (!busy_o && err_o));

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && req_ok) |=> busy_o);

  a_r8_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(|sstb_o));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

bind clksyn_cfg_loader clksyn_loader_sva #(.NCH(NCH)) u_sva (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .chan_i  (chan_i),
  .vdiv_i  (vdiv_i),
  .rdiv_i  (rdiv_i),
  .busy_o  (busy_o),
  .err_o   (err_o),
  .sdat_o  (sdat_o),
  .sclk_o  (sclk_o),
  .sstb_o  (sstb_o)
);

// File: tb/test_clksyn_cfg_loader.sv
`timescale 1ns/1ps
module test_clksyn_cfg_loader;

  localparam int NCH = 3;
  localparam int HC  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] chan_i = '0;
  logic [2:0] odsel_i = '0;
  logic [8:0] vdiv_i = '0;
  logic [6:0] rdiv_i = '0;
  logic       busy_o, err_o;
  logic [2:0] sdat_o, sclk_o, sstb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clksyn_cfg_loader #(.NCH(NCH), .HALF_CYC(HC)) i_clksyn_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .odsel_i(odsel_i), .vdiv_i(vdiv_i), .rdiv_i(rdiv_i),
    .busy_o(busy_o), .err_o(err_o), .sdat_o(sdat_o), .sclk_o(sclk_o),
    .sstb_o(sstb_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({busy_o, err_o, sdat_o, sclk_o, sstb_o} == '0, "R10", "outputs in reset",
        {busy_o, err_o, sdat_o, sclk_o, sstb_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, err_o, sdat_o, sclk_o, sstb_o} == '0, "R10", "outputs after reset",
        {busy_o, err_o, sdat_o, sclk_o, sstb_o}, 0);
  endtask

  // inj: 0 none, 1 illegal request mid-shift, 2 request in last strobe cycle
  task automatic run_xfer(input int ch, input logic [2:0] s, input logic [8:0] v,
                          input logic [6:0] r, input int inj);
    logic [23:0] exp_w, cap;
    int rises, hi_cyc, stb_cyc, busy_cyc, bad_hold, bad_quiet, bad_other;
    logic pclk, pdat, pstb;
    exp_w = {2'b00, 1'b1, 2'b00, s, v, r};
    cap = '0; rises = 0; hi_cyc = 0; stb_cyc = 0; busy_cyc = 0;
    bad_hold = 0; bad_quiet = 0; bad_other = 0;
    pclk = 0; pdat = 0; pstb = 0;
    @(negedge clk);
    chan_i = 2'(ch); odsel_i = s; vdiv_i = v; rdiv_i = r; start_i = 1'b1;
    @(negedge clk);
    while (busy_cyc < 60*HC) begin
      start_i = 1'b0;
      if (!busy_o) break;
      busy_cyc++;
      if (sclk_o[ch] && !pclk) begin
        cap = {cap[22:0], sdat_o[ch]};
        rises++;
      end
      if (sclk_o[ch] && pclk && (sdat_o[ch] != pdat)) bad_hold++;
      if (sclk_o[ch]) hi_cyc++;
      if (sstb_o[ch]) begin
        stb_cyc++;
        if (sclk_o[ch] || sdat_o[ch]) bad_quiet++;
      end
      for (int k = 0; k < NCH; k++)
        if (k != ch && (sclk_o[k] || sdat_o[k] || sstb_o[k])) bad_other++;
      pclk = sclk_o[ch]; pdat = sdat_o[ch]; pstb = sstb_o[ch];
      if (inj == 1 && busy_cyc == 10) begin
        chan_i = 2'((ch + 1) % NCH); vdiv_i = 9'd2; rdiv_i = 7'd0;
        odsel_i = ~s; start_i = 1'b1;
      end
      if (inj == 2 && stb_cyc == 2*HC) begin
        chan_i = 2'((ch + 1) % NCH); vdiv_i = 9'd1; rdiv_i = 7'd5;
        start_i = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(busy_cyc == 50*HC, "R8", "busy length", busy_cyc, 50*HC);
    chk(cap == exp_w, "R1", "word captured", cap, exp_w);
    chk(rises == 24, "R2", "rising edges", rises, 24);
    chk(hi_cyc == 24*HC, "R2", "clock high cycles", hi_cyc, 24*HC);
    chk(bad_hold == 0, "R2", "data moved while clock high", bad_hold, 0);
    chk(stb_cyc == 2*HC, "R3", "strobe length", stb_cyc, 2*HC);
    chk(bad_quiet == 0, "R3", "clock/data during strobe", bad_quiet, 0);
    chk(pstb == 1'b1, "R8", "busy fell with strobe", pstb, 1);
    chk(bad_other == 0, "R9", "other channel activity", bad_other, 0);
    chk({sdat_o, sclk_o, sstb_o} == '0, "R9", "idle outputs",
        {sdat_o, sclk_o, sstb_o}, 0);
    if (inj != 0) begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R8", "request while busy restarted", busy_o, 0);
      chk(err_o == 1'b0, "R8", "request while busy set error", err_o, 0);
    end
  endtask

  task automatic try_bad(input string tag, input int ch, input logic [8:0] v,
                         input logic [6:0] r);
    int act;
    do_reset();
    act = 0;
    chan_i = 2'(ch); odsel_i = 3'd5; vdiv_i = v; rdiv_i = r; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, tag, "error after refused request", err_o, 1);
    for (int n = 0; n < 8; n++) begin
      if (busy_o || sdat_o != 0 || sclk_o != 0 || sstb_o != 0) act++;
      @(negedge clk);
    end
    chk(act == 0, tag, "activity after refused request", act, 0);
  endtask

  initial begin
    test_reset();
    run_xfer(0, 3'b101, 9'h1A5, 7'h53, 0);
    run_xfer(1, 3'b010, 9'd4, 7'd117, 0);
    run_xfer(2, 3'b111, 9'd511, 7'd1, 0);
    run_xfer(1, 3'b001, 9'h0F0, 7'h2A, 1);
    run_xfer(2, 3'b110, 9'h155, 7'h4C, 2);
    try_bad("R4", 0, 9'd3, 7'd10);
    try_bad("R5", 1, 9'd100, 7'd0);
    try_bad("R5", 2, 9'd100, 7'd118);
    try_bad("R6", 3, 9'd100, 7'd10);
    // R7: error stays set across an accepted transfer
    run_xfer(0, 3'b011, 9'h0AA, 7'h33, 0);
    chk(err_o == 1'b1, "R7", "sticky error", err_o, 1);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R7", "sticky error later", err_o, 1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule